// File: doc/BRIEF.md
# PMP Region Bounds Decoder

This block turns one protection entry's settings into an inclusive byte range. It takes three inputs: the entry's two-bit match mode, its address word, and the address word of the entry below it. Address words carry the byte address shifted right by two. The outputs are a start byte address, an end byte address and an active flag. Both addresses are two bits wider than the address word, so a 32-bit word can describe a 34-bit physical space. The block never checks permissions and holds no configuration.

The block has a valid/ready request port and a valid/ready result port. A request is taken on a cycle where `in_valid` and `in_ready` are both high. A result is taken on a cycle where `out_valid` and `out_ready` are both high. Results come out in the order their requests were taken.

Parameter `REG_OUT` selects how the result port behaves:
- With `REG_OUT=1`, one result register sits between the ports. `in_ready` is high when the register is empty or is being drained in the same cycle.
- With `REG_OUT=0`, the result port follows the request port in the same cycle, and back-pressure passes straight through.

The block can be placed once per entry with `out_ready` tied high. It can also be shared across entries: the controller presents each entry in turn as a request, and that request acts as the recompute strobe.

Top module: `pmp_bounds_decoder`

## Requirements
- R1: Mode code 0 (off) gives start 0 and end all ones at the output width.
- R2: Mode code 1 (top-of-range) gives start = previous word × 4 and end = this word × 4 − 1, taken modulo 2^(XLEN+2). A zero word therefore gives an end of all ones.
- R3: In top-of-range mode, when the computed start exceeds the computed end, both outputs are 0.
- R4: In top-of-range mode with `in_first` high, the previous word is treated as 0.
- R5: Mode code 2 (4-byte) gives start = word × 4 and end = start + 3.
- R6: Mode code 3 (naturally aligned power of two) gives a region of 2^(k+3) bytes, where k is the number of trailing one bits of the word. The start is word × 4 rounded down to that size, and the end is start + size − 1. A word ending in 0 gives 8 bytes.
- R7: In mode code 3, an all-ones word covers the whole space: start 0, end all ones.
- R8: `out_active` is 1 exactly when the mode code is not 0.
- R9: `in_prev_addr` and `in_first` have no effect on the result in any mode other than top-of-range.
- R10: With `REG_OUT=1`, the result of a request taken at a clock edge appears on the result port after that edge. While the result register holds a value and `out_ready` is low, `in_ready` is low.
- R11: With `REG_OUT=1`, while `out_valid` is high and `out_ready` is low, the result port holds its values. The result leaves the port on the first edge where `out_ready` is high.
- R12: With `REG_OUT=0`, `out_valid` equals `in_valid` and `in_ready` equals `out_ready`, and the result is valid in the same cycle as the request.
- R13: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken |
| in_mode | input | 2 | Match mode code (0 off, 1 top-of-range, 2 four-byte, 3 power-of-two) |
| in_addr | input | XLEN | This entry's address word (byte address >> 2) |
| in_prev_addr | input | XLEN | Address word of the entry below |
| in_first | input | 1 | Entry has no lower neighbour |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Result can be taken |
| out_start | output | XLEN+2 | Inclusive start byte address |
| out_end | output | XLEN+2 | Inclusive end byte address |
| out_active | output | 1 | Entry can match (mode is not off) |

## Verification
The registered instance's result is due on the negative edge that follows the rising edge at which the request was taken. The bench drops `in_valid` at that same negative edge and samples there. On a stalled request it samples again one full cycle later to confirm the held values and the low `in_ready`. It then raises `out_ready` and checks on the next negative edge that the port has emptied. The combinational instance gets the same stimulus and is sampled one time unit after the inputs change, inside the request cycle, because its result is due in that cycle.

// File: rtl/pmpdec_pkg.sv
package pmpdec_pkg;

  typedef enum logic [1:0] {
    MATCH_OFF   = 2'd0,
    MATCH_TOR   = 2'd1,
    MATCH_NA4   = 2'd2,
    MATCH_NAPOT = 2'd3
  } match_e;

endpackage

// File: rtl/pmpdec_tor.sv
module pmpdec_tor #(
  parameter int AW = 32,
  localparam int BW = AW + 2
) (
  input  logic [AW-1:0] cur_word,
  input  logic [AW-1:0] prev_word,
  input  logic          no_prev,
  output logic [BW-1:0] lo_byte,
  output logic [BW-1:0] hi_byte,
  output logic          collapsed
);

  logic [BW-1:0] lo_raw;
  logic [BW-1:0] hi_raw;

  // Lower bound starts at the neighbour's top; an entry with no neighbour begins at zero.
  always_comb begin
    lo_raw = no_prev ? '0 : {prev_word, 2'b00};
    hi_raw = {cur_word, 2'b00} - BW'(1);
  end

  assign collapsed = lo_raw > hi_raw;
  assign lo_byte   = collapsed ? '0 : lo_raw;
  assign hi_byte   = collapsed ? '0 : hi_raw;

endmodule

// File: rtl/pmpdec_natural.sv
module pmpdec_natural #(
  parameter int AW       = 32,
  parameter bit POW2_SZ  = 1'b1,
  localparam int BW      = AW + 2
) (
  input  logic [AW-1:0] word,
  output logic [BW-1:0] lo_byte,
  output logic [BW-1:0] hi_byte
);

  logic [BW-1:0] filled;
  assign filled = {word, 2'b11};

  generate
    if (POW2_SZ) begin : g_pow2
      logic [BW-1:0] bumped;
      // Adding one clears the run of trailing ones and sets the bit above it.
      assign bumped  = filled + BW'(1);
      assign lo_byte = filled & bumped;
      assign hi_byte = filled | bumped;
    end else begin : g_quad
      assign lo_byte = {word, 2'b00};
      assign hi_byte = filled;
    end
  endgenerate

endmodule

// File: rtl/pmpdec_stage.sv
module pmpdec_stage #(
  parameter int DW      = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);

  generate
    if (REG_OUT) begin : g_reg
      logic          full_q;
      logic [DW-1:0] data_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          full_q <= 1'b0;
          data_q <= '0;
        end else if (in_valid && in_ready) begin
          full_q <= 1'b1;
          data_q <= in_data;
        end else if (out_ready) begin
          full_q <= 1'b0;
        end
      end

      assign in_ready  = !full_q || out_ready;
      assign out_valid = full_q;
      assign out_data  = data_q;
    end else begin : g_wire
      assign in_ready  = out_ready;
      assign out_valid = in_valid;
      assign out_data  = in_data;
    end
  endgenerate

  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready); // R10

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (REG_OUT && out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R11

endmodule

// File: rtl/pmp_bounds_decoder.sv
module pmp_bounds_decoder
  import pmpdec_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter bit REG_OUT = 1'b1,
  localparam int BW     = XLEN + 2,
  localparam int PW     = 2 * BW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [1:0]      in_mode,
  input  logic [XLEN-1:0] in_addr,
  input  logic [XLEN-1:0] in_prev_addr,
  input  logic            in_first,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [BW-1:0]   out_start,
  output logic [BW-1:0]   out_end,
  output logic            out_active
);

  match_e        mode;
  logic [BW-1:0] tor_lo, tor_hi, na4_lo, na4_hi, pow_lo, pow_hi;
  logic          tor_empty;
  logic [BW-1:0] sel_lo, sel_hi;
  logic          sel_active;
  logic [PW-1:0] pack_in, pack_out;

  assign mode = match_e'(in_mode);

  pmpdec_tor #(.AW(XLEN)) u_tor (
    .cur_word  (in_addr),
    .prev_word (in_prev_addr),
    .no_prev   (in_first),
    .lo_byte   (tor_lo),
    .hi_byte   (tor_hi),
    .collapsed (tor_empty)
  );

  pmpdec_natural #(.AW(XLEN), .POW2_SZ(1'b0)) u_na4 (
    .word    (in_addr),
    .lo_byte (na4_lo),
    .hi_byte (na4_hi)
  );

  pmpdec_natural #(.AW(XLEN), .POW2_SZ(1'b1)) u_napot (
    .word    (in_addr),
    .lo_byte (pow_lo),
    .hi_byte (pow_hi)
  );

  always_comb begin
    sel_active = 1'b1;
    unique case (mode)
      MATCH_TOR:   begin sel_lo = tor_lo; sel_hi = tor_hi; end
      MATCH_NA4:   begin sel_lo = na4_lo; sel_hi = na4_hi; end
      MATCH_NAPOT: begin sel_lo = pow_lo; sel_hi = pow_hi; end
      default: begin
        sel_lo     = '0;
        sel_hi     = '1;
        sel_active = 1'b0;
      end
    endcase
  end

  assign pack_in = {sel_active, sel_hi, sel_lo};

  pmpdec_stage #(.DW(PW), .REG_OUT(REG_OUT)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (pack_in),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (pack_out)
  );

  assign out_start  = pack_out[BW-1:0];
  assign out_end    = pack_out[2*BW-1:BW];
  assign out_active = pack_out[PW-1];

  AST_TOR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !tor_empty) |-> (tor_lo <= tor_hi)); // R3

  AST_TOR_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && tor_empty) |-> (tor_lo == '0 && tor_hi == '0)); // R3

  AST_NA4_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> (na4_hi - na4_lo == BW'(3) && na4_lo[1:0] == 2'b00)); // R5

  AST_NAPOT_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ((((pow_hi - pow_lo) & (pow_hi - pow_lo + BW'(1))) == '0)
                  && ((pow_lo & (pow_hi - pow_lo)) == '0)
                  && (pow_hi - pow_lo >= BW'(7)))); // R6

  AST_OFF_WHOLE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_mode == 2'd0) |-> (sel_lo == '0 && (&sel_hi) && !sel_active)); // R1

endmodule

// File: tb/pmp_bounds_decoder_tb.sv
module pmp_bounds_decoder_tb;

  localparam int XLEN = 6;
  localparam int BW   = XLEN + 2;
  localparam int MAXV = (1 << BW) - 1;
  localparam int AMAX = (1 << XLEN) - 1;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            in_valid = 1'b0;
  logic [1:0]      in_mode = '0;
  logic [XLEN-1:0] in_addr = '0;
  logic [XLEN-1:0] in_prev_addr = '0;
  logic            in_first = 1'b0;
  logic            out_ready = 1'b1;

  logic            r_in_ready, r_out_valid, r_out_active;
  logic [BW-1:0]   r_out_start, r_out_end;
  logic            c_in_ready, c_out_valid, c_out_active;
  logic [BW-1:0]   c_out_start, c_out_end;

  int total = 0;
  int failed = 0;
  int txn = 0;

  always #4 clk = ~clk;

  pmp_bounds_decoder #(.XLEN(XLEN), .REG_OUT(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(r_in_ready),
    .in_mode(in_mode), .in_addr(in_addr), .in_prev_addr(in_prev_addr),
    .in_first(in_first), .out_valid(r_out_valid), .out_ready(out_ready),
    .out_start(r_out_start), .out_end(r_out_end), .out_active(r_out_active)
  );

  pmp_bounds_decoder #(.XLEN(XLEN), .REG_OUT(1'b0)) u_dut_comb (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(c_in_ready),
    .in_mode(in_mode), .in_addr(in_addr), .in_prev_addr(in_prev_addr),
    .in_first(in_first), .out_valid(c_out_valid), .out_ready(1'b1),
    .out_start(c_out_start), .out_end(c_out_end), .out_active(c_out_active)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      failed++;
      $display("FAIL %s txn=%0d actual=%0d expected=%0d", tag, txn, act, exp);
    end
  endtask

  task automatic model(input int m, input int a, input int p, input bit f,
                       output int s, output int e, output string tag);
    int k, size;
    case (m)
      0: begin s = 0; e = MAXV; tag = "R1"; end
      1: begin
        s = f ? 0 : p * 4;
        e = (a == 0) ? MAXV : a * 4 - 1;
        tag = f ? "R4" : "R2";
        if (s > e) begin s = 0; e = 0; tag = "R3"; end
      end
      2: begin s = a * 4; e = s + 3; tag = "R5"; end
      default: begin
        if (a == AMAX) begin
          s = 0; e = MAXV; tag = "R7";
        end else begin
          k = 0;
          while (((a >> k) & 1) == 1) k++;
          size = 1 << (k + 3);
          s = ((a * 4) / size) * size;
          e = s + size - 1;
          tag = "R6";
        end
      end
    endcase
    if (m != 1 && (p != 0 || f)) tag = "R9";
  endtask

  task automatic run(input int m, input int a, input int p, input bit f, input bit stall);
    int s, e;
    string tag;
    model(m, a, p, f, s, e, tag);
    txn++;
    @(negedge clk);
    in_mode = 2'(m); in_addr = XLEN'(a); in_prev_addr = XLEN'(p); in_first = f;
    in_valid = 1'b1;
    out_ready = !stall;
    #1;
    // Combinational variant: result due in the request cycle
    chk("R12", int'(c_out_valid), 1);
    chk("R12", int'(c_in_ready), 1);
    chk(tag, int'(c_out_start), s);
    chk(tag, int'(c_out_end), e);
    chk("R8", int'(c_out_active), int'(m != 0));
    chk("R10", int'(r_in_ready), 1);
    @(negedge clk);
    in_valid = 1'b0;
    #1;
    chk("R10", int'(r_out_valid), 1);
    chk(tag, int'(r_out_start), s);
    chk(tag, int'(r_out_end), e);
    chk("R8", int'(r_out_active), int'(m != 0));
    if (stall) begin
      chk("R10", int'(r_in_ready), 0);
      @(negedge clk);
      #1;
      chk("R11", int'(r_out_valid), 1);
      chk("R11", int'(r_out_start), s);
      chk("R11", int'(r_out_end), e);
      chk("R11", int'(r_out_active), int'(m != 0));
      out_ready = 1'b1;
      @(negedge clk);
      #1;
      chk("R11", int'(r_out_valid), 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R13", int'(r_out_valid), 0);
    chk("R13", int'(r_in_ready), 1);
    rst_n = 1'b1;
    // Top-of-range: full sweep of both words
    for (int a = 0; a <= AMAX; a++)
      for (int p = 0; p <= AMAX; p++)
        run(1, a, p, 1'b0, ((a + p) % 16) == 5);
    // Top-of-range with no neighbour
    for (int a = 0; a <= AMAX; a++) begin
      run(1, a, 0, 1'b1, 1'b0);
      run(1, a, AMAX, 1'b1, (a % 8) == 3);
    end
    // Off, four-byte and power-of-two, neighbour inputs varied
    for (int m = 0; m < 4; m++) begin
      if (m == 1) continue;
      for (int a = 0; a <= AMAX; a++) begin
        run(m, a, 0, 1'b0, (a % 16) == 7);
        run(m, a, AMAX, 1'b1, 1'b0);
        run(m, a, a ^ 21, 1'b0, 1'b0);
      end
    end
    repeat (2) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", total, failed);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    failed++;
    $display("FAIL watchdog: run did not complete");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", total, failed);
    $finish;
  end

endmodule